// File: doc/BRIEF.md
# SPI EEPROM Command Controller

This block is the serial command front end of a small byte-addressed nonvolatile store. It acts as an SPI target in clock modes 0 and 3, decodes 8-bit commands, and serves a 2 KB byte array held in a register array. It keeps an 8-bit status word with these fields:

- write-protect enable
- a software flag
- two watchdog period select bits
- two block-lock bits
- the write-enable latch
- a busy indication

The SPI pins are oversampled by the system clock.

A host must set the write-enable latch before any array or status update. Array writes collect up to one 32-byte page in a staging buffer. They commit only when chip select rises exactly on a byte boundary. A committed update starts a self-timed busy interval, during which the status word stays readable and further writes are refused. Reads stream bytes from any start address and roll over at the top of the array.

The control state machine has these states:

- IDLE: chip select is high.
- OPC: collecting the command byte.
- ADDR: collecting the 16-bit address.
- RD: streaming array bytes.
- RS: streaming the status word.
- WD: collecting array write data.
- WS: collecting the status byte.
- TAIL: a complete short command, waiting for chip select to rise.
- SKIP: the frame is ignored until deselect.

Its transitions are:

- IDLE→OPC on the falling edge of chip select.
- From OPC on the 8th bit:
  - to ADDR on read or write;
  - to RS on status read;
  - to WS on status write;
  - to TAIL on set-latch, clear-latch or set-flag;
  - to SKIP on any other code.
- ADDR→RD or ADDR→WD on the 16th address bit.
- WS→TAIL on its 8th bit.
- TAIL→SKIP on any further bit.
- Any state→IDLE while chip select is high.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After power-on reset the status word reads 0x00 and `so_oe` is low.
- R2: Command 0x06 sets the write-enable latch (status bit 1) only if chip select rises right after its 8th bit; a frame with more or fewer bits leaves the latch unchanged.
- R3: Command 0x00 sets the flag (status bit 6); command 0x04 clears both the flag and the write-enable latch.
- R4: Array writes (0x02) and status writes (0x01) are refused when the write-enable latch is clear.
- R5: An array write commits only if chip select rises after a whole number (at least one) of data bytes; otherwise no byte of it is stored.
- R6: Write data bytes go to consecutive addresses that wrap within the 32-byte page of the start address (low 5 bits); a later byte to the same location replaces an earlier one.
- R7: Command 0x03 followed by a 16-bit address streams bytes MSB first on `so`, each bit changing on the falling SCK edge. The address increments after each byte and rolls from 0x7FF to 0x000; only the low 11 address bits are used.
- R8: A committed write sets the busy bit (status bit 0) for BUSY_CYC clocks while the status word stays readable; the write-enable latch clears when the interval ends.
- R9: Array and status writes issued while busy is set are ignored.
- R10: Block-lock code (status bits 3:2) 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF, 11 protects all. A write to a protected page stores nothing, starts no busy interval and leaves the latch set; protected bytes stay readable.
- R11: A status write is refused when write-protect enable (status bit 7) is 1 and `wp_n` is low; with that bit 0 the `wp_n` level is ignored.
- R12: A status write loads data bits 7:2 into status bits 7:2; data bits 1:0 are ignored and status bits 1:0 are read-only.
- R13: Modes 0 and 3 both work; `so_oe` is high only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| por_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data in, sampled on rising SCK |
| wp_n | input | 1 | Active-low hardware write protect for the status word |
| so | output | 1 | Serial data out, changes on falling SCK |
| so_oe | output | 1 | Output enable for `so` |

## Verification
The bench targets frames that end one bit early or late: a set-latch command of 9 bits and a write cut 3 bits into its second byte. A design that acts on the command byte alone would set the latch or store a partial page there. A 35-byte write starting near the end of a page checks that the column wraps and that later bytes overwrite earlier ones; an address counter that carries into the page number would corrupt the neighbouring page. All four block-lock codes are swept against an address in each protection range, with the expected outcome computed from the range bounds; a wrong range decode shows up as stored or missing bytes. The write-protect pin is toggled against the enable bit, reads roll across the top of the array, and writes are attempted during the busy interval, where a design that fails to block them would overwrite committed data.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_RS, ST_WD, ST_WS, ST_TAIL, ST_SKIP
    } ee_state_t;

    localparam logic [7:0] OP_SETWEL = 8'h06;
    localparam logic [7:0] OP_CLRWEL = 8'h04;
    localparam logic [7:0] OP_SETFLG = 8'h00;
    localparam logic [7:0] OP_RDSTAT = 8'h05;
    localparam logic [7:0] OP_WRSTAT = 8'h01;
    localparam logic [7:0] OP_RDARR  = 8'h03;
    localparam logic [7:0] OP_WRARR  = 8'h02;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
    parameter int CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left <= '0;
        else if (start && left == '0)
            left <= CW'(CYC);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign busy = (left != '0);
    assign done = (left == CW'(1));
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int PAGE_W   = 5,
    parameter int BUSY_CYC = 5000
) (
    input  logic clk,
    input  logic por_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int PAGE_SZ = 1 << PAGE_W;
    localparam int PG_W    = ADDR_W - PAGE_W;

    logic [2:0] pin_s;
    logic       cs_s, sck_s, si_s, cs_d, sck_d;
    logic       sck_rise, sck_fall, cs_fall, cs_rise;

    spi_ee_sync #(.W(3), .INIT(3'b100)) u_sync (
        .clk(clk), .rst_n(por_n), .d({cs_n, sck, si}), .q(pin_s)
    );
    assign {cs_s, sck_s, si_s} = pin_s;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d & ~cs_s;
    assign sck_fall = ~sck_s & sck_d & ~cs_s;
    assign cs_fall  = ~cs_s & cs_d;
    assign cs_rise  = cs_s & ~cs_d;

    ee_state_t           state, nxt;
    logic [3:0]          cnt;
    logic [15:0]         shreg;
    logic [7:0]          op_q, op_in;
    logic [15:0]         addr_in;
    logic [ADDR_W-1:0]   addr;
    logic [PAGE_W-1:0]   col;
    logic [PAGE_SZ-1:0]  vmask;
    logic                got_byte, byte_end;
    logic                wpen, flag, wel, wip;
    logic [1:0]          wd, bl;
    logic                busy_done, busy_start, wr_prot, st_go, arr_go, so_r;
    logic [7:0]          status;
    logic [7:0]          mem  [DEPTH];
    logic [7:0]          pbuf [PAGE_SZ];

    assign op_in    = {shreg[6:0], si_s};
    assign addr_in  = {shreg[14:0], si_s};
    assign byte_end = (cnt[2:0] == 3'd7);
    assign status   = {wpen, flag, wd, bl, wel, wip};

    always_comb begin
        unique case (bl)
            2'b00: wr_prot = 1'b0;
            2'b01: wr_prot = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
            2'b10: wr_prot = addr[ADDR_W-1];
            2'b11: wr_prot = 1'b1;
        endcase
    end

    assign st_go  = cs_rise && state == ST_TAIL && op_q == OP_WRSTAT &&
                    wel && !wip && !(wpen && !wp_n);
    assign arr_go = cs_rise && state == ST_WD && cnt == 4'd0 && got_byte &&
                    wel && !wip && !wr_prot;
    assign busy_start = st_go | arr_go;

    spi_ee_busy #(.CYC(BUSY_CYC)) u_busy (
        .clk(clk), .rst_n(por_n), .start(busy_start), .busy(wip), .done(busy_done)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (cs_fall)
            nxt = ST_OPC;
        else if (cs_s)
            nxt = ST_IDLE;
        else if (sck_rise) begin
            unique case (state)
                ST_OPC:
                    if (byte_end) begin
                        unique case (op_in)
                            OP_RDARR, OP_WRARR:             nxt = ST_ADDR;
                            OP_RDSTAT:                      nxt = ST_RS;
                            OP_WRSTAT:                      nxt = ST_WS;
                            OP_SETWEL, OP_CLRWEL, OP_SETFLG: nxt = ST_TAIL;
                            default:                        nxt = ST_SKIP;
                        endcase
                    end
                ST_ADDR: if (cnt == 4'd15) nxt = (op_q == OP_RDARR) ? ST_RD : ST_WD;
                ST_WS:   if (byte_end) nxt = ST_TAIL;
                ST_TAIL: nxt = ST_SKIP;
                default: nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0; shreg <= '0; op_q <= '0; addr <= '0; col <= '0;
            vmask <= '0; got_byte <= 1'b0; so_r <= 1'b0;
            wpen <= 1'b0; flag <= 1'b0; wel <= 1'b0; wd <= '0; bl <= '0;
        end else begin
            if (cs_fall) begin
                cnt      <= '0;
                got_byte <= 1'b0;
                vmask    <= '0;
                so_r     <= 1'b0;
            end else if (sck_rise) begin
                shreg <= addr_in;
                cnt   <= (byte_end && state != ST_ADDR) ? 4'd0 : cnt + 4'd1;
                unique case (state)
                    ST_OPC:  if (byte_end) op_q <= op_in;
                    ST_ADDR: if (cnt == 4'd15) begin
                                 addr <= addr_in[ADDR_W-1:0];
                                 col  <= addr_in[PAGE_W-1:0];
                             end
                    ST_RD:   if (byte_end) addr <= addr + 1'b1;
                    ST_WD:   if (byte_end) begin
                                 vmask[col] <= 1'b1;
                                 col        <= col + 1'b1;
                                 got_byte   <= 1'b1;
                             end
                    default: ;
                endcase
            end else if (sck_fall) begin
                if (state == ST_RD) so_r <= mem[addr][3'd7 - cnt[2:0]];
                if (state == ST_RS) so_r <= status[3'd7 - cnt[2:0]];
            end

            if (busy_done) wel <= 1'b0;
            if (cs_rise && state == ST_TAIL) begin
                unique case (op_q)
                    OP_SETWEL: wel <= 1'b1;
                    OP_CLRWEL: begin wel <= 1'b0; flag <= 1'b0; end
                    OP_SETFLG: flag <= 1'b1;
                    default: ;
                endcase
            end
            if (st_go) {wpen, flag, wd, bl} <= shreg[7:2];
        end
    end

    // staging buffer and array
    always_ff @(posedge clk) begin
        if (sck_rise && state == ST_WD && byte_end)
            pbuf[col] <= op_in;
        for (int i = 0; i < PAGE_SZ; i++)
            if (arr_go && vmask[i])
                mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
    end

    assign so    = so_r;
    assign so_oe = ~cs_n & ~cs_s;

    logic [PG_W-1:0] unused_pg;
    assign unused_pg = addr[ADDR_W-1:PAGE_W];
endmodule

module spi_ee_chk (
    input logic clk,
    input logic por_n,
    input logic cs_n,
    input logic so_oe,
    input logic wp_n,
    input logic wpen,
    input logic wel,
    input logic wip,
    input logic in_wd,
    input logic wr_prot
);
    // R13
    oe_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        cs_n |-> !so_oe);

    // R11
    wpen_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wpen && !wp_n) |=> wpen);

    // R4
    wel_needed_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wip) |-> $past(wel));

    // R8
    wel_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wip) |-> !wel);

    // R10
    prot_block_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(wip) && $past(in_wd)) |-> !$past(wr_prot));

    // R1
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rst_state_chk: assert (!wel && !wip && !wpen);
        end
    end
endmodule

bind spi_eeprom_ctrl spi_ee_chk u_chk (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .so_oe(so_oe), .wp_n(wp_n),
    .wpen(wpen), .wel(wel), .wip(wip), .in_wd(state == spi_ee_pkg::ST_WD),
    .wr_prot(wr_prot)
);

// File: tb/sim_spi_eeprom_ctrl.sv
module sim_spi_eeprom_ctrl;
    localparam int CLK_NS = 10;
    localparam int HALF   = 4;
    localparam int BUSY   = 1500;

    logic clk = 1'b0;
    logic por_n, cs_n, sck, si, wp_n, so, so_oe;
    int   total = 0, bad = 0;
    bit   finished = 0;
    logic [7:0] tx [0:39];
    logic [7:0] rx [0:39];
    logic       oe_mid;
    logic [7:0] st, shadow [0:2];

    always #(CLK_NS/2) clk = ~clk;

    spi_eeprom_ctrl #(.BUSY_CYC(BUSY)) u0 (
        .clk(clk), .por_n(por_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic frame(input int nb, input int xb, input bit m3);
        sck = m3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < nb * 8 + xb; k++) begin
            if (m3) sck = 1'b0;
            si = tx[k/8][7 - (k%8)];
            repeat (HALF) @(negedge clk);
            rx[k/8][7 - (k%8)] = so;
            if (k == 0) oe_mid = so_oe;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (!m3) sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        tx[0] = op;
        frame(1, 0, 0);
    endtask

    task automatic rdsr(output logic [7:0] v);
        tx[0] = 8'h05; tx[1] = 8'h00;
        frame(2, 0, 0);
        v = rx[1];
    endtask

    task automatic wrsr(input logic [7:0] v);
        cmd(8'h06);
        tx[0] = 8'h01; tx[1] = v;
        frame(2, 0, 0);
    endtask

    task automatic wr_arr(input logic [15:0] a, input int n, input logic [7:0] v);
        tx[0] = 8'h02; tx[1] = a[15:8]; tx[2] = a[7:0];
        for (int i = 0; i < n; i++) tx[3+i] = v + 8'(i);
        frame(3 + n, 0, 0);
    endtask

    task automatic rd_arr(input logic [15:0] a, input int n, input bit m3);
        tx[0] = 8'h03; tx[1] = a[15:8]; tx[2] = a[7:0];
        for (int i = 0; i < n; i++) tx[3+i] = 8'h00;
        frame(3 + n, 0, m3);
    endtask

    task automatic wait_busy;
        repeat (BUSY + 100) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; wp_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 so_oe in reset", {7'd0, so_oe}, 8'h00);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        rdsr(st); check("R1 status after reset", st, 8'h00);
        check("R13 so_oe during frame", {7'd0, oe_mid}, 8'h01);
        check("R13 so_oe after frame", {7'd0, so_oe}, 8'h00);

        // R2 latch set and framing
        cmd(8'h06); rdsr(st); check("R2 set latch", st, 8'h02);
        cmd(8'h04); rdsr(st); check("R3 clear latch", st, 8'h00);
        tx[0] = 8'h06; tx[1] = 8'h00; frame(1, 1, 0);
        rdsr(st); check("R2 nine-bit frame", st, 8'h00);
        tx[0] = 8'h06; frame(0, 5, 0);
        rdsr(st); check("R2 five-bit frame", st, 8'h00);

        // R3 flag
        cmd(8'h00); rdsr(st); check("R3 flag set", st, 8'h40);
        cmd(8'h06); rdsr(st); check("R3 flag and latch", st, 8'h42);
        cmd(8'h04); rdsr(st); check("R3 clear both", st, 8'h00);

        // R8 / R5 basic write
        cmd(8'h06); wr_arr(16'h0100, 1, 8'h5A);
        rdsr(st); check("R8 busy after commit", st, 8'h03);
        wait_busy;
        rdsr(st); check("R8 latch cleared", st, 8'h00);
        rd_arr(16'h0100, 1, 0); check("R5 byte stored", rx[3], 8'h5A);

        // R4 write without latch
        wr_arr(16'h0100, 1, 8'h11); rdsr(st); check("R4 no busy", st, 8'h00);
        rd_arr(16'h0100, 1, 0); check("R4 unchanged", rx[3], 8'h5A);

        // R5 cut mid-byte
        cmd(8'h06);
        tx[0] = 8'h02; tx[1] = 8'h01; tx[2] = 8'h00; tx[3] = 8'hA5; tx[4] = 8'hFF;
        frame(4, 3, 0);
        rdsr(st); check("R5 cut frame no busy", st, 8'h02);
        rd_arr(16'h0100, 1, 0); check("R5 cut frame discarded", rx[3], 8'h5A);

        // R6 page wrap sweep: 35 bytes from column 0x1D of page 0x220
        wr_arr(16'h023D, 35, 8'h30);
        wait_busy;
        rd_arr(16'h0220, 32, 0);
        for (int c = 0; c < 32; c++) begin
            int i;
            i = (c - 29 + 32) % 32;
            if (i < 3) i = i + 32;
            check($sformatf("R6 col %0d", c), rx[3+c], 8'(8'h30 + i));
        end

        // R7 rollover and upper address bits
        cmd(8'h06); wr_arr(16'h07FE, 2, 8'hC0); wait_busy;
        cmd(8'h06); wr_arr(16'h0000, 1, 8'hD0); wait_busy;
        rd_arr(16'h07FE, 3, 0);
        check("R7 byte 7FE", rx[3], 8'hC0);
        check("R7 byte 7FF", rx[4], 8'hC1);
        check("R7 rollover to 000", rx[5], 8'hD0);
        rd_arr(16'hF7FE, 1, 0); check("R7 upper bits ignored", rx[3], 8'hC0);
        rd_arr(16'h07FE, 3, 1);
        check("R13 mode3 read", rx[3], 8'hC0);
        check("R13 mode3 rollover", rx[5], 8'hD0);

        // R9 write during busy
        cmd(8'h06); wr_arr(16'h0300, 1, 8'h77);
        cmd(8'h06); wr_arr(16'h0300, 1, 8'h88);
        wait_busy;
        rd_arr(16'h0300, 1, 0); check("R9 busy write ignored", rx[3], 8'h77);

        // R12 status field
        wrsr(8'h33); rdsr(st); check("R12 busy after status write", st, 8'h33);
        wait_busy; rdsr(st); check("R12 status fields", st, 8'h30);
        wrsr(8'h00); wait_busy;

        // R10 block lock sweep
        for (int b = 0; b < 4; b++) begin
            wrsr(8'(b << 2)); wait_busy;
            for (int q = 0; q < 3; q++) begin
                logic [15:0] a;
                logic [7:0]  v;
                bit          prot;
                a = (q == 0) ? 16'h0040 : (q == 1) ? 16'h0440 : 16'h0640;
                v = 8'(8'h80 + b * 8 + q);
                prot = (b == 3) || (b == 2 && a >= 16'h0400) || (b == 1 && a >= 16'h0600);
                cmd(8'h06); wr_arr(a, 1, v);
                rdsr(st);
                check($sformatf("R10 status bl=%0d q=%0d", b, q), st,
                      8'(b << 2) | (prot ? 8'h02 : 8'h03));
                wait_busy;
                if (!prot) shadow[q] = v;
                rd_arr(a, 1, 0);
                check($sformatf("R10 data bl=%0d q=%0d", b, q), rx[3], shadow[q]);
            end
        end
        wrsr(8'h00); wait_busy;

        // R11 write protect pin and enable
        wrsr(8'h80); wait_busy; rdsr(st); check("R11 enable set", st, 8'h80);
        wp_n = 1'b0;
        wrsr(8'h00); rdsr(st); check("R11 locked refuses", st, 8'h82);
        cmd(8'h04);
        wp_n = 1'b1;
        wrsr(8'h00); wait_busy; rdsr(st); check("R11 unlocked accepts", st, 8'h00);
        wp_n = 1'b0;
        wrsr(8'h08); wait_busy; rdsr(st); check("R11 pin ignored when disabled", st, 8'h08);
        wp_n = 1'b1;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule